// File: doc/BRIEF.md
# Region Cacheability Attribute File

This block stores one cacheability flag for each 16 MB slice of a 32-bit byte address space. A cache controller queries it through a combinational lookup port on every access. An instruction fetch is always reported cacheable. A data access takes the stored flag for its slice.

Software-facing logic reaches the flags through a single command port with a valid/ready handshake. A read command returns the flag of the slice that holds a given address. A range command writes a 0 or a 1 into every slice touched by a byte range, given as a base address and a byte length. The range command works through the slices at one per clock. It holds a busy flag until it is done and accepts no other command in the meantime.

Top module: `region_attr_file`

## Requirements
- R1: After reset every flag is 0 (non-cacheable), `busy` is 0 and `cmd_ready` is 1.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. A read command has `cmd_op`=0. In the cycle after acceptance, a read drives `rd_valid`=1 and `rd_bit` equal to the flag of slice `cmd_addr[31:24]`. In all other cycles `rd_valid` is 0.
- R3: A range command has `cmd_op`=1 and a nonzero `cmd_len`. It writes `cmd_val` into every slice from `cmd_addr[31:24]` up to the slice of the last byte, `cmd_addr+cmd_len-1`. No other slice changes.
- R4: A range command with `cmd_len`=0 changes no flag and never raises `busy`.
- R5: When `cmd_addr+cmd_len-1` lies beyond 0xFFFF_FFFF, the range ends at slice 255. It does not wrap to slice 0.
- R6: A range command covering N slices holds `busy` at 1 for exactly N cycles after acceptance. `cmd_ready` is 0 whenever `busy` is 1.
- R7: A command presented while `busy` is 1 is ignored. It writes no flag and produces no read response.
- R8: `lk_cacheable` follows `lk_addr` and `lk_is_prog` combinationally. It is 1 when `lk_is_prog`=1, and otherwise equals the flag of slice `lk_addr[31:24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 1 | 0 = read flag, 1 = range write |
| cmd_addr | input | 32 | Byte address (read) or range base |
| cmd_len | input | 32 | Range length in bytes |
| cmd_val | input | 1 | Flag value written by a range command |
| rd_valid | output | 1 | Read response present |
| rd_bit | output | 1 | Flag returned by a read |
| busy | output | 1 | Range command in progress |
| lk_addr | input | 32 | Access address to classify |
| lk_is_prog | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_cacheable | output | 1 | Access may be cached |

## Verification
The bench builds the block with its default parameters: a 32-bit address and an 8-bit slice index, so 256 slices of 16 MB each. These real sizes let the bench reach the slice edges directly. It covers a last byte ending exactly on a 16 MB boundary, a two-byte range that straddles two slices, and a range whose end overflows past 0xFFFF_FFFF and must stop at slice 255. The bench also counts `busy` cycles on a four-slice range, and it presents a command during that range to show the command is dropped.

// File: rtl/region_attr_file.sv
module region_attr_file #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_len,
  input  logic              cmd_val,
  output logic              rd_valid,
  output logic              rd_bit,
  output logic              busy,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_is_prog,
  output logic              lk_cacheable
);
  localparam int NREG  = 1 << IDX_W;
  localparam int SHIFT = ADDR_W - IDX_W;

  logic [NREG-1:0]  attr_q;
  logic             busy_q, val_q;
  logic [IDX_W-1:0] cur_q, last_q;
  logic [ADDR_W:0]  end_addr;
  logic [IDX_W-1:0] first_idx, last_idx;
  logic             accept;

  assign accept    = cmd_valid && !busy_q;
  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign end_addr  = {1'b0, cmd_addr} + {1'b0, cmd_len} - {{ADDR_W{1'b0}}, 1'b1};
  assign first_idx = cmd_addr[ADDR_W-1:SHIFT];
  assign last_idx  = end_addr[ADDR_W] ? {IDX_W{1'b1}} : end_addr[ADDR_W-1:SHIFT];
  assign lk_cacheable = lk_is_prog | attr_q[lk_addr[ADDR_W-1:SHIFT]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q   <= '0;
      busy_q   <= 1'b0;
      val_q    <= 1'b0;
      cur_q    <= '0;
      last_q   <= '0;
      rd_valid <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      rd_valid <= accept && !cmd_op;
      if (accept && !cmd_op) rd_bit <= attr_q[first_idx];
      if (busy_q) begin
        attr_q[cur_q] <= val_q;
        if (cur_q == last_q) busy_q <= 1'b0;
        else                 cur_q  <= cur_q + 1'b1;
      end else if (accept && cmd_op && (cmd_len != '0)) begin
        busy_q <= 1'b1;
        val_q  <= cmd_val;
        cur_q  <= first_idx;
        last_q <= last_idx;
      end
    end
  end

  // R8
  prog_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_is_prog |-> lk_cacheable);

  // R4
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op && cmd_len == '0) |=> !busy);

  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_op) |=> rd_valid);

  // R7
  no_rd_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);

  // R4
  attr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_op)) |=> $stable(attr_q));

  // R5
  cur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_q <= last_q));
endmodule

// File: tb/region_attr_file_tb.sv
module region_attr_file_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_op = 0, cmd_val = 0, lk_is_prog = 0;
  logic [31:0] cmd_addr = 0, cmd_len = 0, lk_addr = 0;
  logic        cmd_ready, rd_valid, rd_bit, busy, lk_cacheable;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  region_attr_file u_dut (.*);

  // {op, addr, len, val, exp}
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 32'h4200_0000, 32'h0100_0000, 1'b1, 1'b0},
    {1'b0, 32'h4234_5678, 32'h0,         1'b0, 1'b1},
    {1'b0, 32'h4300_0000, 32'h0,         1'b0, 1'b0},
    {1'b0, 32'h41FF_FFFF, 32'h0,         1'b0, 1'b0},
    {1'b1, 32'h8000_0010, 32'h0300_0000, 1'b1, 1'b0},
    {1'b0, 32'h83FF_FFFF, 32'h0,         1'b0, 1'b1},
    {1'b0, 32'h8400_0000, 32'h0,         1'b0, 1'b0},
    {1'b0, 32'h8000_0000, 32'h0,         1'b0, 1'b1},
    {1'b1, 32'h8100_0000, 32'h1,         1'b0, 1'b0},
    {1'b0, 32'h8100_0000, 32'h0,         1'b0, 1'b0},
    {1'b0, 32'h8200_0000, 32'h0,         1'b0, 1'b1},
    {1'b1, 32'h10FF_FFFF, 32'h2,         1'b1, 1'b0},
    {1'b0, 32'h1100_0001, 32'h0,         1'b0, 1'b1},
    {1'b0, 32'h1000_0000, 32'h0,         1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic op, input logic [31:0] a, input logic [31:0] l, input logic v);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_len = l; cmd_val = v;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic read_chk(input logic [31:0] a, input logic exp, input string req);
    issue(1'b0, a, 32'h0, 1'b0);
    check(rd_valid === 1'b1, req, int'(rd_valid), 1);
    check(rd_bit === exp, req, int'(rd_bit), int'(exp));
    @(negedge clk);
    check(rd_valid === 1'b0, "R2 pulse", int'(rd_valid), 0);
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(cmd_ready === 1'b1, "R1 ready", int'(cmd_ready), 1);
    lk_addr = 32'h4200_0000; lk_is_prog = 0; #1;
    check(lk_cacheable === 1'b0, "R1 lookup", int'(lk_cacheable), 0);
    read_chk(32'hFFFF_FFFF, 1'b0, "R1 read");

    foreach (VEC[i]) begin
      if (VEC[i][66]) begin
        issue(1'b1, VEC[i][65:34], VEC[i][33:2], VEC[i][1]);
        wait_idle(n);
      end else begin
        read_chk(VEC[i][65:34], VEC[i][0], "R3 table");
      end
    end

    // R6 four slices, busy exactly 4 cycles
    issue(1'b1, 32'h2000_0000, 32'h0400_0000, 1'b1);
    wait_idle(n);
    check(n == 4, "R6 busy cycles", n, 4);
    read_chk(32'h23FF_FFFF, 1'b1, "R6 last slice");
    read_chk(32'h2400_0000, 1'b0, "R3 beyond");

    // R7 command during busy is dropped
    issue(1'b1, 32'h5000_0000, 32'h0300_0000, 1'b1);
    @(negedge clk);
    check(cmd_ready === 1'b0, "R6 ready low", int'(cmd_ready), 0);
    cmd_valid = 1; cmd_op = 1; cmd_addr = 32'h3000_0000; cmd_len = 32'h10; cmd_val = 1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_addr = 32'h3000_0000;
    @(negedge clk);
    cmd_valid = 0;
    check(rd_valid === 1'b0, "R7 no read", int'(rd_valid), 0);
    wait_idle(n);
    read_chk(32'h3000_0000, 1'b0, "R7 dropped range");
    read_chk(32'h5200_0000, 1'b1, "R3 range done");

    // R4 zero length
    issue(1'b1, 32'h6000_0000, 32'h0, 1'b1);
    check(busy === 1'b0, "R4 no busy", int'(busy), 0);
    read_chk(32'h6000_0000, 1'b0, "R4 unchanged");
    issue(1'b1, 32'h4200_0000, 32'h0, 1'b0);
    read_chk(32'h4200_0000, 1'b1, "R4 keeps one");

    // R5 clip at top
    issue(1'b1, 32'hFF80_0000, 32'h0200_0000, 1'b1);
    wait_idle(n);
    check(n == 1, "R5 one slice", n, 1);
    read_chk(32'hFF00_0000, 1'b1, "R5 top set");
    read_chk(32'h0000_0000, 1'b0, "R5 no wrap 0");
    read_chk(32'h0100_0000, 1'b0, "R5 no wrap 1");

    // R8 lookup
    lk_addr = 32'h0000_1234; lk_is_prog = 1; #1;
    check(lk_cacheable === 1'b1, "R8 prog", int'(lk_cacheable), 1);
    lk_is_prog = 0; #1;
    check(lk_cacheable === 1'b0, "R8 data clear", int'(lk_cacheable), 0);
    lk_addr = 32'h82AB_CDEF; #1;
    check(lk_cacheable === 1'b1, "R8 data set", int'(lk_cacheable), 1);
    lk_addr = 32'h8100_0000; #1;
    check(lk_cacheable === 1'b0, "R8 data cleared", int'(lk_cacheable), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule